// File: doc/BRIEF.md
# Converter Trigger and Sample Queue

This block sits between an analog-to-digital converter and a processor register port. It watches a bus of asynchronous event lines. It picks one line by a 6-bit source code, synchronizes every line through two flops and detects the chosen edge of the selected line. On that edge it sends a single-cycle start pulse to the converter. Software can also fire a start pulse directly by writing a trigger bit.

Samples that come back from the converter are marked by a valid strobe and go into a four-entry queue of 12-bit words. Software drains the queue through a data register. A write to that same register pushes a dummy sample, which helps when no converter is attached. A status register shows the empty, full and exactly-three-entries flags, plus two sticky error flags: one for a push into a full queue and one for a pop from an empty queue. Only a flush command clears those error flags.

A small state machine follows the 2-bit command field and has three states. OFF (command 0, and the unsupported code 2) ignores triggers and converter samples. RUN (command 1) passes triggers and captures samples. FLUSH (command 3) holds the queue empty and its flags clear. The state register loads the command on every clock, so these transitions exist: OFF to RUN, RUN to OFF, OFF or RUN to FLUSH, and FLUSH back to OFF or RUN. Each transition takes effect one cycle after the command register changes.

Top module: `adc_trig_fifo`

Register map (2-bit address): 0 = control, 1 = trigger, 2 = data, 3 = status.

## Requirements
- R1: After reset, the status register reads 0x01 (empty only). The control register reads 0x3F00 (source code 0x3F, command 0, polarity 0). `start_o` is low.
- R2: In RUN, a change on the selected event line is applied before rising edge n and crosses two synchronizer flops. If it is the chosen edge, `start_o` is high for exactly the one cycle that follows rising edge n+2.
- R3: Control bit 4 selects the trigger edge: 0 means rising, 1 means falling. The opposite edge produces no pulse.
- R4: Control bits [13:8] select the event line. Code 0x3F and the codes with no defined source (0x2C, 0x2D, 0x39 to 0x3C, 0x3E) never produce a pulse. The written code still reads back unchanged.
- R5: Writing trigger bit 0 = 1 in RUN raises `start_o` for the one cycle after the write edge. Writing 0 has no effect.
- R6: Control bits [1:0] hold the command: 0 = OFF, 1 = RUN, 3 = FLUSH, and 2 behaves as OFF. In OFF, event edges, manual triggers and converter samples are all ignored.
- R7: In RUN, each cycle with `smp_valid_i` high queues `smp_data_i`. Reading the data register returns the oldest entry in bits [11:0] and removes it in the same cycle.
- R8: Status bits are: bit0 empty, bit1 full (four entries), bit2 almost-full (exactly three entries, 0 when four are held), bit3 overflow, bit4 underflow.
- R9: A push into a full queue is dropped and sets overflow. Overflow stays set, and while it is set no push is accepted, even after entries have been read.
- R10: A read of an empty queue returns the last sample read and sets underflow. Underflow stays set, and while it is set reads return that same sample and remove nothing.
- R11: Command FLUSH empties the queue and clears overflow and underflow. Nothing can be queued while in FLUSH.
- R12: A bus write to the data register queues bits [11:0] in OFF and RUN. If a converter sample arrives in the same cycle, the converter sample is queued and the bus write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 64 | Asynchronous event lines |
| smp_valid_i | input | 1 | Converter sample valid strobe |
| smp_data_i | input | 12 | Converter sample value |
| start_o | output | 1 | Single-cycle converter start pulse |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops when addressing data) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the current address |

## Verification
A corrupted queue pointer or level shows up at the next data read as a sample out of order, or as a status word whose empty, full and almost-full bits disagree with the count of pushes and pops. Both appear within one read after the fault. A stuck state machine shows up when a trigger or sample is accepted or lost in the wrong command. The start pulse timing is checked exactly three edges after the event changes, so an extra or missing synchronizer stage moves the pulse by a full cycle. A sticky flag that clears early, or a frozen pointer that moves, shows up in the next status or data read after the offending access.

// File: rtl/adctf_pkg.sv
package adctf_pkg;

    typedef enum logic [1:0] {
        CMD_OFF   = 2'd0,
        CMD_RUN   = 2'd1,
        CMD_RSVD  = 2'd2,
        CMD_FLUSH = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2
    } state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_TRIG = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_POL_BIT = 4;
    localparam int CTRL_SRC_LSB = 8;

    localparam int STAT_EMPTY = 0;
    localparam int STAT_FULL  = 1;
    localparam int STAT_AFULL = 2;
    localparam int STAT_OVF   = 3;
    localparam int STAT_UNF   = 4;

endpackage

// File: rtl/adctf_evt_edge.sv
module adctf_evt_edge #(
    parameter int EVT_W = 64,
    parameter logic [EVT_W-1:0] VALID_MASK = '1,
    localparam int SRC_W = $clog2(EVT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic             pol_i,
    output logic             edge_o
);

    logic [EVT_W-1:0] rise;
    logic [EVT_W-1:0] fall;

    // Two synchronizer stages plus one history stage per line.
    for (genvar g = 0; g < EVT_W; g++) begin : g_line
        logic [2:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[1:0], evt_i[g]};
            end
        end
        assign rise[g] = pipe_q[1] & ~pipe_q[2];
        assign fall[g] = ~pipe_q[1] & pipe_q[2];
    end

    logic src_defined;
    assign src_defined = VALID_MASK[src_i];

    always_comb begin
        edge_o = 1'b0;
        if (src_defined) begin
            edge_o = pol_i ? fall[src_i] : rise[src_i];
        end
    end

endmodule

// File: rtl/adctf_ctrl_fsm.sv
module adctf_ctrl_fsm
    import adctf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd_i,
    output logic run_o,
    output logic flush_o
);

    state_e state_q;
    state_e state_d;

    always_comb begin
        unique case (cmd_i)
            CMD_RUN:   state_d = ST_RUN;
            CMD_FLUSH: state_d = ST_FLUSH;
            default:   state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        run_o   = 1'b0;
        flush_o = 1'b0;
        unique case (state_q)
            ST_RUN:   run_o   = 1'b1;
            ST_FLUSH: flush_o = 1'b1;
            default: begin
                run_o   = 1'b0;
                flush_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adctf_fifo.sv
module adctf_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          empty_o,
    output logic          full_o,
    output logic          afull_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam logic [LVL_W-1:0] LVL_FULL  = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_AFULL = LVL_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST  = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic [DW-1:0]    last_q;
    logic             ovf_q;
    logic             unf_q;

    logic push_ok;
    logic pop_ok;

    assign empty_o = (level_q == '0);
    assign full_o  = (level_q == LVL_FULL);
    assign afull_o = (level_q == LVL_AFULL);
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;

    assign push_ok = push_i & ~full_o & ~ovf_q;
    assign pop_ok  = pop_i & ~empty_o & ~unf_q;

    assign head_o = (empty_o | unf_q) ? last_q : mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push_ok && !clr_i) begin
            mem[wr_ptr_q] <= push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            last_q   <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else if (clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            if (push_i && (full_o || ovf_q)) begin
                ovf_q <= 1'b1;
            end
            if (pop_i && (empty_o || unf_q)) begin
                unf_q <= 1'b1;
            end
            if (push_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
                last_q   <= mem[rd_ptr_q];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   level_q <= level_q + 1'b1;
                2'b01:   level_q <= level_q - 1'b1;
                default: level_q <= level_q;
            endcase
        end
    end

endmodule

// File: rtl/adc_trig_fifo.sv
module adc_trig_fifo
    import adctf_pkg::*;
#(
    parameter int EVT_W = 64,
    parameter int DEPTH = 4,
    parameter int SMP_W = 12,
    parameter logic [EVT_W-1:0] VALID_MASK = 64'h21FF_CFFF_FFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              smp_valid_i,
    input  logic [SMP_W-1:0]  smp_data_i,
    output logic              start_o,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o
);

    localparam int SRC_W = $clog2(EVT_W);

    cmd_e             cmd_q;
    logic             pol_q;
    logic [SRC_W-1:0] src_q;
    logic             start_q;

    logic wr_ctrl, wr_trig, wr_data, rd_data;
    logic manual_trig;
    logic evt_edge;
    logic fsm_run, fsm_flush;

    logic             conv_push, bus_push, q_push;
    logic [SMP_W-1:0] q_push_data;
    logic [SMP_W-1:0] q_head;
    logic f_empty, f_full, f_afull, f_ovf, f_unf;

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata_i;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign wr_trig = reg_wr_i && (reg_addr_i == ADDR_TRIG);
    assign wr_data = reg_wr_i && (reg_addr_i == ADDR_DATA);
    assign rd_data = reg_rd_i && (reg_addr_i == ADDR_DATA);

    assign manual_trig = wr_trig & reg_wdata_i[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CMD_OFF;
            pol_q <= 1'b0;
            src_q <= '1;
        end else if (wr_ctrl) begin
            cmd_q <= cmd_e'(reg_wdata_i[1:0]);
            pol_q <= reg_wdata_i[CTRL_POL_BIT];
            src_q <= reg_wdata_i[CTRL_SRC_LSB +: SRC_W];
        end
    end

    adctf_evt_edge #(
        .EVT_W      (EVT_W),
        .VALID_MASK (VALID_MASK)
    ) u_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .src_i  (src_q),
        .pol_i  (pol_q),
        .edge_o (evt_edge)
    );

    adctf_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_i   (cmd_q),
        .run_o   (fsm_run),
        .flush_o (fsm_flush)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= fsm_run & (evt_edge | manual_trig);
        end
    end
    assign start_o = start_q;

    assign conv_push   = fsm_run & smp_valid_i;
    assign bus_push    = wr_data & ~fsm_flush;
    assign q_push      = conv_push | bus_push;
    assign q_push_data = conv_push ? smp_data_i : reg_wdata_i[SMP_W-1:0];

    adctf_fifo #(
        .DEPTH (DEPTH),
        .DW    (SMP_W)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (fsm_flush),
        .push_i      (q_push),
        .push_data_i (q_push_data),
        .pop_i       (rd_data),
        .head_o      (q_head),
        .empty_o     (f_empty),
        .full_o      (f_full),
        .afull_o     (f_afull),
        .ovf_o       (f_ovf),
        .unf_o       (f_unf)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[1:0]                  = cmd_q;
                reg_rdata_o[CTRL_POL_BIT]         = pol_q;
                reg_rdata_o[CTRL_SRC_LSB +: SRC_W] = src_q;
            end
            ADDR_DATA: reg_rdata_o[SMP_W-1:0] = q_head;
            ADDR_STAT: begin
                reg_rdata_o[STAT_EMPTY] = f_empty;
                reg_rdata_o[STAT_FULL]  = f_full;
                reg_rdata_o[STAT_AFULL] = f_afull;
                reg_rdata_o[STAT_OVF]   = f_ovf;
                reg_rdata_o[STAT_UNF]   = f_unf;
            end
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/adctf_chk.sv
module adctf_chk (
    input logic clk,
    input logic rst_n,
    input logic start_o,
    input logic run,
    input logic flush,
    input logic empty,
    input logic full,
    input logic afull,
    input logic ovf,
    input logic unf
);

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(run));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R8
    afull_only_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        afull |-> (!full && !empty));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);

    // R9
    ovf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> !$rose(full));

    // R10
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !flush) |=> unf);

    // R10
    unf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !flush) |=> !$rose(empty));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !ovf && !unf));

endmodule

bind adc_trig_fifo adctf_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_o (start_o),
    .run     (fsm_run),
    .flush   (fsm_flush),
    .empty   (f_empty),
    .full    (f_full),
    .afull   (f_afull),
    .ovf     (f_ovf),
    .unf     (f_unf)
);

// File: tb/tb_adc_trig_fifo.sv
module tb_adc_trig_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        start;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    adc_trig_fifo dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .start_o     (start),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] c, input logic p, input logic [5:0] s);
        return (32'(s) << 8) | (32'(p) << 4) | 32'(c);
    endfunction

    task automatic set_mode(input logic [1:0] c, input logic p, input logic [5:0] s);
        reg_write(2'd0, ctrl_word(c, p, s));
        repeat (2) @(negedge clk);
    endtask

    task automatic do_flush(input logic [1:0] next_cmd);
        reg_write(2'd0, ctrl_word(2'd3, 1'b0, 6'h3F));
        repeat (3) @(negedge clk);
        set_mode(next_cmd, 1'b0, 6'h3F);
    endtask

    task automatic push_smp(input logic [11:0] v);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Change one event line and check start pulse window (3 edges later).
    task automatic evt_expect(input string req, input int idx, input logic val, input logic exp);
        @(negedge clk);
        evt[idx] = val;
        @(negedge clk); chk(req, 32'(start), 32'd0);
        @(negedge clk); chk(req, 32'(start), 32'd0);
        @(negedge clk); chk(req, 32'(start), 32'(exp));
        @(negedge clk); chk(req, 32'(start), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(2'd3, d); chk("R1 status", d, 32'h01);
        peek(2'd0, d); chk("R1 control", d, 32'h3F00);
        chk("R1 start", 32'(start), 32'd0);
    endtask

    task automatic t_manual();
        set_mode(2'd1, 1'b0, 6'h3F);
        reg_write(2'd1, 32'h0);
        chk("R5 write zero", 32'(start), 32'd0);
        reg_write(2'd1, 32'h1);
        chk("R5 pulse", 32'(start), 32'd1);
        @(negedge clk);
        chk("R5 single cycle", 32'(start), 32'd0);
    endtask

    task automatic t_rise();
        set_mode(2'd1, 1'b0, 6'd5);
        evt_expect("R2 rising edge", 5, 1'b1, 1'b1);
        evt_expect("R3 falling ignored with pol 0", 5, 1'b0, 1'b0);
        evt_expect("R2 other line ignored", 6, 1'b1, 1'b0);
        evt[6] = 1'b0;
    endtask

    task automatic t_fall();
        set_mode(2'd1, 1'b1, 6'h30);
        evt_expect("R3 rising ignored with pol 1", 48, 1'b1, 1'b0);
        evt_expect("R3 falling edge", 48, 1'b0, 1'b1);
    endtask

    task automatic t_invalid();
        logic [31:0] d;
        set_mode(2'd1, 1'b0, 6'h2C);
        peek(2'd0, d); chk("R4 readback", d, ctrl_word(2'd1, 1'b0, 6'h2C));
        evt_expect("R4 undefined code", 44, 1'b1, 1'b0);
        evt[44] = 1'b0;
        set_mode(2'd1, 1'b0, 6'h3F);
        evt_expect("R4 no-event code", 63, 1'b1, 1'b0);
        evt[63] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_off();
        logic [31:0] d;
        set_mode(2'd0, 1'b0, 6'd5);
        evt_expect("R6 event in OFF", 5, 1'b1, 1'b0);
        evt[5] = 1'b0;
        repeat (3) @(negedge clk);
        reg_write(2'd1, 32'h1);
        chk("R6 manual in OFF", 32'(start), 32'd0);
        push_smp(12'hABC);
        peek(2'd3, d); chk("R6 sample ignored in OFF", d, 32'h01);
        set_mode(2'd2, 1'b0, 6'h3F);
        reg_write(2'd1, 32'h1);
        chk("R6 code 2 behaves as OFF", 32'(start), 32'd0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        do_flush(2'd1);
        push_smp(12'h111); push_smp(12'h222); push_smp(12'h333);
        peek(2'd3, d); chk("R8 three entries almost full", d, 32'h04);
        push_smp(12'h444);
        peek(2'd3, d); chk("R8 four entries full", d, 32'h02);
        reg_read(2'd2, d); chk("R7 first out", d, 32'h111);
        reg_read(2'd2, d); chk("R7 second out", d, 32'h222);
        reg_read(2'd2, d); chk("R7 third out", d, 32'h333);
        peek(2'd3, d); chk("R8 one entry", d, 32'h00);
        reg_read(2'd2, d); chk("R7 fourth out", d, 32'h444);
        peek(2'd3, d); chk("R8 empty again", d, 32'h01);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        do_flush(2'd1);
        for (int i = 1; i <= 4; i++) push_smp(12'(i));
        push_smp(12'h0F5);
        peek(2'd3, d); chk("R9 overflow set", d, 32'h0A);
        reg_read(2'd2, d); chk("R9 head kept", d, 32'h001);
        push_smp(12'h0F6);
        peek(2'd3, d); chk("R9 push frozen", d, 32'h0C);
        reg_read(2'd2, d); chk("R9 data 2", d, 32'h002);
        reg_read(2'd2, d); chk("R9 data 3", d, 32'h003);
        reg_read(2'd2, d); chk("R9 data 4", d, 32'h004);
        peek(2'd3, d); chk("R9 overflow sticky", d, 32'h09);
        do_flush(2'd1);
        peek(2'd3, d); chk("R11 flush clears overflow", d, 32'h01);
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        do_flush(2'd1);
        push_smp(12'h5A5);
        reg_read(2'd2, d); chk("R10 normal read", d, 32'h5A5);
        reg_read(2'd2, d); chk("R10 empty read repeats", d, 32'h5A5);
        peek(2'd3, d); chk("R10 underflow set", d, 32'h11);
        push_smp(12'h777);
        reg_read(2'd2, d); chk("R10 frozen read", d, 32'h5A5);
        peek(2'd3, d); chk("R10 entry not removed", d, 32'h10);
        reg_write(2'd0, ctrl_word(2'd3, 1'b0, 6'h3F));
        reg_write(2'd2, 32'h123);
        push_smp(12'h456);
        peek(2'd3, d); chk("R11 flush empties and blocks", d, 32'h01);
        set_mode(2'd1, 1'b0, 6'h3F);
        peek(2'd3, d); chk("R11 still empty after leaving", d, 32'h01);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        do_flush(2'd0);
        reg_write(2'd2, 32'hFFFF_F9AB);
        peek(2'd3, d); chk("R12 dummy queued in OFF", d, 32'h00);
        reg_read(2'd2, d); chk("R12 dummy value", d, 32'h9AB);
        set_mode(2'd1, 1'b0, 6'h3F);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 12'hC01;
        addr = 2'd2; wdata = 32'h0D02; wr = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; wr = 1'b0;
        reg_read(2'd2, d); chk("R12 converter wins", d, 32'hC01);
        peek(2'd3, d); chk("R12 bus write dropped", d, 32'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_manual();
        t_rise();
        t_fall();
        t_invalid();
        t_off();
        t_order();
        t_overflow();
        t_underflow();
        t_bus();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule